// File: doc/BRIEF.md
# Clock Mode Selector with Oscillator Supervision

This block picks how the CPU clock is produced. While reset is held it captures a 3-bit configuration field and a supervision enable pin. From these two values it selects one of three modes. In direct drive the oscillator clock feeds the CPU. In prescaler mode the oscillator is divided by two. In PLL mode the multiplied PLL output feeds the CPU. The captured values then stay frozen until the next reset. The supervision enable pin gates two things: the PLL and the oscillator watchdog. When that pin is low, a configuration that would need the PLL is redirected to a non-PLL mode, chosen by the top configuration bit.

In direct drive and prescaler mode the PLL is not in the CPU clock path. If supervision is enabled, the PLL free-runs at its base frequency and its clock supervises the oscillator. The oscillator level is synchronized into the base-clock domain, and each change of level restarts a counter. When the time since the last change runs past a limit, a fail flag is set, and only reset clears it. The analog PLL is represented only by the base clock input. The CPU clock mux itself sits outside the block and is steered by the select output and by a per-cycle oscillator enable.

Top module: `clk_mode_ctrl`

## Requirements
- R1: Configuration 3'b011 selects direct drive: mode = 2'b00, clk_sel = 0, and cpu_clk_en is 1 on every oscillator cycle.
- R2: Configuration 3'b001 selects the prescaler: mode = 2'b01, clk_sel = 0, and cpu_clk_en is 1 on exactly every second oscillator cycle (oscillator divided by 2).
- R3: With the enable pin high, every other configuration selects PLL mode: mode = 2'b10, clk_sel = 1, pll_en = 1, wd_en = 0, cpu_clk_en = 0.
- R4: With the enable pin low, pll_en = 0 and wd_en = 0 in every mode.
- R5: With the enable pin low and a PLL configuration, the block falls back to direct drive (mode 2'b00) when cfg[2] = 1 and to the prescaler (mode 2'b01) when cfg[2] = 0.
- R6: With the enable pin high in direct drive or prescaler mode, pll_en = 1 (PLL free-running at base frequency) and wd_en = 1.
- R7: Configuration and enable pins are sampled only while rst_n is low; changes after release leave mode, pll_en, wd_en and clk_sel unchanged.
- R8: While wd_en = 1, osc_fail sets once more than WD_LIMIT base-clock cycles pass with no synchronized oscillator level change; gaps of WD_LIMIT or fewer cycles never set it.
- R9: Once set, osc_fail stays 1 even if the oscillator resumes, until rst_n is asserted.
- R10: While wd_en = 0, osc_fail stays 0 even if the oscillator stops.
- R11: While rst_n is low and just after its release, osc_fail = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_clk | input | 1 | Free-running PLL base clock model; clocks capture and watchdog |
| osc_clk | input | 1 | Oscillator clock under supervision |
| rst_n | input | 1 | Active-low reset; configuration is captured while low |
| cfg_pins | input | 3 | Clock configuration field |
| sup_en_pin | input | 1 | Enable for PLL and oscillator watchdog (1 = enabled) |
| mode | output | 2 | 00 direct drive, 01 prescaler, 10 PLL |
| pll_en | output | 1 | PLL powered |
| wd_en | output | 1 | Oscillator watchdog active |
| clk_sel | output | 1 | 1 = CPU clock from PLL, 0 = from oscillator |
| cpu_clk_en | output | 1 | Per-oscillator-cycle enable for the oscillator CPU clock path |
| osc_fail | output | 1 | Sticky oscillator failure flag |

## Verification
The mode, pll_en, wd_en and clk_sel outputs are decoded combinationally from registers loaded on each base-clock edge during reset. They are therefore read several base cycles after the pins are set and again after release, always at the falling base edge. cpu_clk_en changes one flop after a rising oscillator edge, so it is sampled at falling oscillator edges and its high count is taken over eight cycles. osc_fail rises between about WD_LIMIT and WD_LIMIT+5 base cycles after the oscillator stops, because the synchronizer and the last half period both add delay. The bench reads it well inside that window as still low, and well after the window as set.

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl #(
  parameter int CFG_W    = 3,
  parameter int WD_LIMIT = 16
) (
  input  logic             base_clk,
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_pins,
  input  logic             sup_en_pin,
  output logic [1:0]       mode,
  output logic             pll_en,
  output logic             wd_en,
  output logic             clk_sel,
  output logic             cpu_clk_en,
  output logic             osc_fail
);
  localparam int CNT_W = $clog2(WD_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(WD_LIMIT);
  localparam logic [1:0] M_DIRECT = 2'b00;
  localparam logic [1:0] M_PRESC  = 2'b01;
  localparam logic [1:0] M_PLL    = 2'b10;
  localparam logic [CFG_W-1:0] CFG_DIRECT = CFG_W'(3);
  localparam logic [CFG_W-1:0] CFG_PRESC  = CFG_W'(1);

  logic [CFG_W-1:0] cfg_q;
  logic             en_q;

  always_ff @(posedge base_clk) begin
    if (!rst_n) begin
      cfg_q <= cfg_pins;
      en_q  <= sup_en_pin;
    end
  end

  always_comb begin
    if (cfg_q == CFG_DIRECT)     mode = M_DIRECT;
    else if (cfg_q == CFG_PRESC) mode = M_PRESC;
    else if (en_q)               mode = M_PLL;
    else if (cfg_q[CFG_W-1])     mode = M_DIRECT;
    else                         mode = M_PRESC;
  end

  assign pll_en  = en_q;
  assign clk_sel = (mode == M_PLL);
  assign wd_en   = en_q && (mode != M_PLL);

  logic div_tgl;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) div_tgl <= 1'b0;
    else        div_tgl <= ~div_tgl;
  end

  assign cpu_clk_en = (mode == M_PRESC) ? div_tgl : (mode == M_DIRECT);

  logic [2:0]       osc_sync;
  logic             osc_edge;
  logic [CNT_W-1:0] gap_cnt;

  always_ff @(posedge base_clk or negedge rst_n) begin
    if (!rst_n) osc_sync <= '0;
    else        osc_sync <= {osc_sync[1:0], osc_clk};
  end

  assign osc_edge = osc_sync[2] ^ osc_sync[1];

  always_ff @(posedge base_clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt  <= '0;
      osc_fail <= 1'b0;
    end else begin
      if (!wd_en || osc_edge) gap_cnt <= '0;
      else if (gap_cnt != LIM) gap_cnt <= gap_cnt + 1'b1;
      if (wd_en && !osc_edge && gap_cnt == LIM) osc_fail <= 1'b1;
    end
  end
endmodule

// File: rtl/clk_mode_chk.sv
module clk_mode_chk (
  input logic       base_clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       pll_en,
  input logic       wd_en,
  input logic       clk_sel,
  input logic       osc_fail
);
  p_pll_outputs_r3: assert property (@(posedge base_clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (clk_sel && pll_en && !wd_en));

  p_en_low_r4: assert property (@(posedge base_clk) disable iff (!rst_n)
    !pll_en |-> (!wd_en && mode != 2'b10));

  p_frozen_cfg_r7: assert property (@(posedge base_clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(mode) && $stable(pll_en)));

  p_fail_sticky_r9: assert property (@(posedge base_clk) disable iff (!rst_n)
    osc_fail |=> osc_fail);

  p_no_fail_off_r10: assert property (@(posedge base_clk) disable iff (!rst_n)
    !wd_en |-> !osc_fail);

  p_reset_clear_r11: assert property (@(posedge base_clk)
    !rst_n |-> !osc_fail);
endmodule

bind clk_mode_ctrl clk_mode_chk u_chk (
  .base_clk(base_clk), .rst_n(rst_n), .mode(mode), .pll_en(pll_en),
  .wd_en(wd_en), .clk_sel(clk_sel), .osc_fail(osc_fail)
);

// File: tb/clk_mode_ctrl_bench.sv
`timescale 1ns/1ps
module clk_mode_ctrl_bench;
  logic       base_clk = 1'b0;
  logic       osc_clk  = 1'b0;
  logic       rst_n    = 1'b0;
  logic [2:0] cfg_pins = 3'b011;
  logic       sup_en_pin = 1'b1;
  logic [1:0] mode;
  logic       pll_en, wd_en, clk_sel, cpu_clk_en, osc_fail;

  int  n_run  = 0;
  int  n_fail = 0;
  int  osc_half = 10;
  bit  osc_run  = 1'b1;
  bit  done     = 1'b0;

  always #2 base_clk = ~base_clk;

  initial begin
    forever begin
      if (osc_run) #(osc_half) osc_clk = ~osc_clk;
      else #4;
    end
  end

  clk_mode_ctrl u_clk_mode_ctrl (
    .base_clk(base_clk), .osc_clk(osc_clk), .rst_n(rst_n),
    .cfg_pins(cfg_pins), .sup_en_pin(sup_en_pin), .mode(mode),
    .pll_en(pll_en), .wd_en(wd_en), .clk_sel(clk_sel),
    .cpu_clk_en(cpu_clk_en), .osc_fail(osc_fail)
  );

  // {cfg, en, mode, pll_en, wd_en, clk_sel}
  localparam logic [8:0] VEC [16] = '{
    9'b000_1_10_1_0_1, 9'b000_0_01_0_0_0,
    9'b001_1_01_1_1_0, 9'b001_0_01_0_0_0,
    9'b010_1_10_1_0_1, 9'b010_0_01_0_0_0,
    9'b011_1_00_1_1_0, 9'b011_0_00_0_0_0,
    9'b100_1_10_1_0_1, 9'b100_0_00_0_0_0,
    9'b101_1_10_1_0_1, 9'b101_0_00_0_0_0,
    9'b110_1_10_1_0_1, 9'b110_0_00_0_0_0,
    9'b111_1_10_1_0_1, 9'b111_0_00_0_0_0
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_base(input int n);
    for (int i = 0; i < n; i++) @(negedge base_clk);
  endtask

  task automatic do_reset(input logic [2:0] c, input logic e);
    @(negedge base_clk);
    rst_n = 1'b0;
    cfg_pins = c;
    sup_en_pin = e;
    wait_base(4);
    chk(osc_fail == 1'b0, "R11 fail low in reset", osc_fail, 0);
    rst_n = 1'b1;
    wait_base(3);
  endtask

  task automatic count_en(output int highs);
    highs = 0;
    @(negedge osc_clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge osc_clk);
      if (cpu_clk_en) highs++;
    end
  endtask

  initial begin
    #400000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int highs;
    int exp_highs;
    wait_base(3);

    for (int k = 0; k < 16; k++) begin
      logic [8:0] v;
      v = VEC[k];
      do_reset(v[8:6], v[5]);
      chk(mode == v[4:3], "R1/R2/R3/R5 mode", mode, v[4:3]);
      chk(pll_en == v[2], "R4/R6 pll_en", pll_en, v[2]);
      chk(wd_en == v[1], "R4/R6 wd_en", wd_en, v[1]);
      chk(clk_sel == v[0], "R3 clk_sel", clk_sel, v[0]);
      chk(osc_fail == 1'b0, "R11 fail after release", osc_fail, 0);
      count_en(highs);
      exp_highs = (v[4:3] == 2'b00) ? 8 : (v[4:3] == 2'b01) ? 4 : 0;
      chk(highs == exp_highs, "R1/R2/R3 cpu_clk_en count", highs, exp_highs);
    end

    // R7: pins changed after release are ignored
    do_reset(3'b011, 1'b1);
    cfg_pins = 3'b000;
    sup_en_pin = 1'b0;
    wait_base(20);
    chk(mode == 2'b00, "R7 mode frozen", mode, 0);
    chk(pll_en == 1'b1, "R7 pll_en frozen", pll_en, 1);
    chk(wd_en == 1'b1, "R7 wd_en frozen", wd_en, 1);

    // R8: slow but live oscillator, gaps below limit
    do_reset(3'b001, 1'b1);
    osc_half = 40;
    wait_base(300);
    chk(osc_fail == 1'b0, "R8 no fail at 10-cycle gaps", osc_fail, 0);
    osc_half = 10;
    wait_base(50);
    chk(osc_fail == 1'b0, "R8 no fail at fast osc", osc_fail, 0);

    // R8: oscillator stops
    osc_run = 1'b0;
    wait_base(10);
    chk(osc_fail == 1'b0, "R8 fail not early", osc_fail, 0);
    wait_base(20);
    chk(osc_fail == 1'b1, "R8 fail after stop", osc_fail, 1);

    // R9: sticky after oscillator resumes
    osc_run = 1'b1;
    wait_base(100);
    chk(osc_fail == 1'b1, "R9 fail sticky", osc_fail, 1);
    do_reset(3'b001, 1'b1);
    chk(osc_fail == 1'b0, "R9 reset clears fail", osc_fail, 0);

    // R10: watchdog off (enable low), oscillator stops
    do_reset(3'b011, 1'b0);
    osc_run = 1'b0;
    wait_base(80);
    chk(osc_fail == 1'b0, "R10 no fail enable low", osc_fail, 0);
    osc_run = 1'b1;

    // R10: PLL mode, oscillator stops
    do_reset(3'b110, 1'b1);
    osc_run = 1'b0;
    wait_base(80);
    chk(osc_fail == 1'b0, "R10 no fail in PLL mode", osc_fail, 0);
    osc_run = 1'b1;

    // R8: direct drive with watchdog, stop
    do_reset(3'b011, 1'b1);
    wait_base(20);
    osc_run = 1'b0;
    wait_base(40);
    chk(osc_fail == 1'b1, "R8 fail in direct mode", osc_fail, 1);
    osc_run = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule